// File: doc/BRIEF.md
# ADC Power-Down and Initialization Sequencer

This block sits between the active-low power-down pin of an audio converter and the converter's digital output path. While the pin is low it holds the decimation filter in reset and forces both channel samples to zero. After the pin is released it waits for the sample clocks to start. It then counts frame edges of the word-select clock through a fixed initialization period. Only after that period does it let live left and right samples through.

The length of the zero-forced period depends on the clocking role. As clock master the count starts at once and runs 4129 frames. As clock slave the block stays in power-down until the first frame edge of the selected format arrives. It then counts 4132 further frames. That frame edge is the rising word-select edge in left-justified format and the falling edge in I2S format. The role and format are sampled while the block is powered down. Once the block has left power-down, changes to them have no effect.

The block also refuses to start until the power-down pin has been pulled low at least once since the last system reset. This enforces the rule that a reset cycle must follow power-up.

Top module: `adcseq_top`

## Requirements
- R1: While `rst_i` is high and on the first cycle after it falls, `filt_rst_o`=1, `zero_force_o`=1, `ready_o`=0, and both sample outputs are zero.
- R2: After a system reset the block stays in power-down (`filt_rst_o`=1, `ready_o`=0) while `pdn_i` stays high, until `pdn_i` has been low at least once.
- R3: `pdn_i` passes through a two-flop synchronizer. A low level at any point, including mid-count, returns the block to power-down three clock edges later and clears the frame count, so the next release starts a full count.
- R4: In master mode (`master_i`=1), `filt_rst_o` falls on the third clock edge after release. `ready_o` rises after 4129 counted frame edges.
- R5: In slave mode, `filt_rst_o` stays high after release until the first frame edge: rising `ws_i` when `i2s_i`=0, falling `ws_i` when `i2s_i`=1. That edge is not counted. `ready_o` rises after 4132 further frame edges of the same polarity.
- R6: While `ready_o` is low, `zero_force_o`=1 and both sample outputs are zero. Once ready, `left_o`/`right_o` carry `left_i`/`right_i` sampled at the previous clock edge.
- R7: The frame count saturates at its terminal value. `ready_o` stays high until the next power-down.
- R8: `master_i` and `i2s_i` are captured on every cycle spent in power-down. Changes to them after release have no effect until the next power-down.
- R9: `filt_rst_o` is high in the power-down state and while a slave waits for its first frame edge, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_i | input | 1 | Synchronous active-high system reset |
| pdn_i | input | 1 | Asynchronous power-down pin, low = power down |
| master_i | input | 1 | 1 = clock master, 0 = clock slave |
| i2s_i | input | 1 | 1 = I2S framing (falling frame edge), 0 = left-justified (rising frame edge) |
| ws_i | input | 1 | Word-select clock, synchronous to clk_i |
| left_i | input | DATA_W | Live left-channel sample |
| right_i | input | DATA_W | Live right-channel sample |
| filt_rst_o | output | 1 | Decimation filter reset |
| zero_force_o | output | 1 | Samples are being forced to zero |
| ready_o | output | 1 | Initialization complete, live data flowing |
| left_o | output | DATA_W | Gated left sample |
| right_o | output | DATA_W | Gated right sample |

## Verification
The bench counts word-select edges from each release up to the rise of `ready_o` in both roles and both framings. An off-by-one terminal count, a slave that counts its start edge, or a wrong edge polarity moves that count out of its one-edge window. It aborts a count midway and then checks a full new count. A counter that is not cleared would finish early. It flips role and format in the middle of a count. A design that reads them live would switch to the shorter count or the other edge. It also holds the pin high after reset to catch a block that starts without the mandatory reset pulse.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_WAIT = 2'd1,
    ST_INIT = 2'd2,
    ST_RUN  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/adcseq_sync.sv
module adcseq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) chain_q <= {STAGES{RST_VAL}};
    else       chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/adcseq_frame_edge.sv
module adcseq_frame_edge (
  input  logic clk_i,
  input  logic rst_i,
  input  logic ws_i,
  input  logic fall_sel_i,
  output logic evt_o
);
  logic ws_q, ws_qq;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ws_q  <= 1'b0;
      ws_qq <= 1'b0;
    end else begin
      ws_q  <= ws_i;
      ws_qq <= ws_q;
    end
  end

  assign evt_o = fall_sel_i ? (ws_qq & ~ws_q) : (ws_q & ~ws_qq);
endmodule

// File: rtl/adcseq_init_ctr.sv
module adcseq_init_ctr #(
  parameter int CNT_W         = 13,
  parameter int MASTER_FRAMES = 4129,
  parameter int SLAVE_FRAMES  = 4132
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic             slave_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] M_TERM = CNT_W'(MASTER_FRAMES);
  localparam logic [CNT_W-1:0] S_TERM = CNT_W'(SLAVE_FRAMES);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term;

  assign term = slave_i ? S_TERM : M_TERM;

  always_ff @(posedge clk_i) begin
    if (rst_i || clear_i)            cnt_q <= '0;
    else if (step_i && cnt_q != term) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == term - 1'b1);

  assert_cnt_bound_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_q <= term);

  assert_cnt_saturate_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (cnt_q == term && !clear_i && $stable(slave_i)) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/adcseq_data_gate.sv
module adcseq_data_gate #(
  parameter int DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              pass_i,
  input  logic [DATA_W-1:0] left_i,
  input  logic [DATA_W-1:0] right_i,
  output logic [DATA_W-1:0] left_o,
  output logic [DATA_W-1:0] right_o,
  output logic              zero_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      left_o  <= '0;
      right_o <= '0;
      zero_o  <= 1'b1;
    end else begin
      left_o  <= pass_i ? left_i  : '0;
      right_o <= pass_i ? right_i : '0;
      zero_o  <= ~pass_i;
    end
  end
endmodule

// File: rtl/adcseq_top.sv
module adcseq_top
  import adcseq_pkg::*;
#(
  parameter int DATA_W        = 24,
  parameter int CNT_W         = 13,
  parameter int MASTER_FRAMES = 4129,
  parameter int SLAVE_FRAMES  = 4132,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              pdn_i,
  input  logic              master_i,
  input  logic              i2s_i,
  input  logic              ws_i,
  input  logic [DATA_W-1:0] left_i,
  input  logic [DATA_W-1:0] right_i,
  output logic              filt_rst_o,
  output logic              zero_force_o,
  output logic              ready_o,
  output logic [DATA_W-1:0] left_o,
  output logic [DATA_W-1:0] right_o
);
  seq_state_e       st_q, st_nxt;
  logic             pd_up;
  logic             seen_q;
  logic             master_q, i2s_q;
  logic             evt;
  logic             ctr_clear, ctr_step, ctr_last;
  logic [CNT_W-1:0] ctr_val;

  adcseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pd_sync (
    .clk_i (clk_i), .rst_i (rst_i), .d_i (pdn_i), .q_o (pd_up)
  );

  adcseq_frame_edge u_edge (
    .clk_i (clk_i), .rst_i (rst_i), .ws_i (ws_i),
    .fall_sel_i (i2s_q), .evt_o (evt)
  );

  assign ctr_clear = (st_q == ST_OFF) || (st_q == ST_WAIT);
  assign ctr_step  = (st_q == ST_INIT) && evt;

  adcseq_init_ctr #(
    .CNT_W (CNT_W), .MASTER_FRAMES (MASTER_FRAMES), .SLAVE_FRAMES (SLAVE_FRAMES)
  ) u_ctr (
    .clk_i (clk_i), .rst_i (rst_i), .clear_i (ctr_clear), .step_i (ctr_step),
    .slave_i (~master_q), .cnt_o (ctr_val), .last_o (ctr_last)
  );

  always_comb begin
    st_nxt = st_q;
    if (!pd_up) begin
      st_nxt = ST_OFF;
    end else begin
      unique case (st_q)
        ST_OFF:  if (seen_q) st_nxt = master_i ? ST_INIT : ST_WAIT;
        ST_WAIT: if (evt) st_nxt = ST_INIT;
        ST_INIT: if (evt && ctr_last) st_nxt = ST_RUN;
        ST_RUN:  st_nxt = ST_RUN;
        default: st_nxt = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st_q       <= ST_OFF;
      seen_q     <= 1'b0;
      master_q   <= 1'b0;
      i2s_q      <= 1'b0;
      filt_rst_o <= 1'b1;
      ready_o    <= 1'b0;
    end else begin
      st_q <= st_nxt;
      if (!pd_up) seen_q <= 1'b1;
      if (st_q == ST_OFF) begin
        master_q <= master_i;
        i2s_q    <= i2s_i;
      end
      filt_rst_o <= (st_nxt == ST_OFF) || (st_nxt == ST_WAIT);
      ready_o    <= (st_nxt == ST_RUN);
    end
  end

  adcseq_data_gate #(.DATA_W (DATA_W)) u_gate (
    .clk_i (clk_i), .rst_i (rst_i), .pass_i (st_nxt == ST_RUN),
    .left_i (left_i), .right_i (right_i),
    .left_o (left_o), .right_o (right_o), .zero_o (zero_force_o)
  );

  assert_no_start_before_pd_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    !seen_q |-> filt_rst_o);

  assert_pd_forces_off_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    !pd_up |=> (st_q == ST_OFF && filt_rst_o && !ready_o));

  assert_ready_after_init_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(ready_o) |-> ($past(st_q) == ST_INIT && $past(evt)));

  assert_zero_until_run_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (st_q != ST_RUN) |-> (zero_force_o && left_o == '0 && right_o == '0));

  assert_ready_holds_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (ready_o && pd_up) |=> ready_o);

  assert_mode_frozen_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (st_q == ST_INIT || st_q == ST_RUN) |=> ($stable(master_q) && $stable(i2s_q)));
endmodule

// File: tb/adcseq_top_tb_top.sv
module adcseq_top_tb_top;
  localparam int DW   = 24;
  localparam int MF   = 4129;
  localparam int SF   = 4132;
  localparam int HALF = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, pdn, master, i2s, ws;
  logic [DW-1:0] l_in, r_in;
  logic filt_rst_o, zero_force_o, ready_o;
  logic [DW-1:0] left_o, right_o;

  adcseq_top dut_i (
    .clk_i (clk), .rst_i (rst), .pdn_i (pdn), .master_i (master), .i2s_i (i2s),
    .ws_i (ws), .left_i (l_in), .right_i (r_in),
    .filt_rst_o (filt_rst_o), .zero_force_o (zero_force_o), .ready_o (ready_o),
    .left_o (left_o), .right_o (right_o)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // stimulus: word-select and sample data, changed just after falling edges
  int rise_cnt = 0;
  int fall_cnt = 0;
  initial begin
    int ph;
    ph = 0; ws = 1'b0; l_in = '0; r_in = '0;
    forever begin
      @(negedge clk); #1;
      l_in = DW'($urandom);
      r_in = DW'($urandom);
      ph++;
      if (ph == HALF) begin
        ph = 0;
        ws = ~ws;
        if (ws) rise_cnt++; else fall_cnt++;
      end
    end
  end

  // behavioural reference model: phase 0 off, 1 waiting, 2 counting, 3 running
  int m_ph = 0;
  int m_cnt = 0;
  bit m_seen, m_master, m_i2s;
  bit pd1, pd2, w1, w2;
  bit e_filt, e_zero, e_ready;
  logic [DW-1:0] e_l, e_r;
  bit mvalid = 0;

  always @(posedge clk) begin
    bit pe, evt, was_off, cm, ci;
    int t;
    if (rst) begin
      m_ph = 0; m_cnt = 0; m_seen = 0; m_master = 0; m_i2s = 0;
      pd1 = 1; pd2 = 1; w1 = 0; w2 = 0;
      mvalid = 1;
    end else begin
      pe = pd2;
      evt = m_i2s ? (w2 && !w1) : (w1 && !w2);
      t = m_master ? MF : SF;
      was_off = (m_ph == 0);
      cm = master; ci = i2s;
      if (!pe) begin
        m_ph = 0; m_seen = 1; m_cnt = 0;
      end else begin
        case (m_ph)
          0: if (m_seen) begin m_ph = cm ? 2 : 1; m_cnt = 0; end
          1: if (evt) begin m_ph = 2; m_cnt = 0; end
          2: if (evt) begin
               if (m_cnt == t - 1) m_ph = 3;
               m_cnt++;
             end
          default: ;
        endcase
      end
      if (was_off) begin m_master = cm; m_i2s = ci; end
      pd2 = pd1; pd1 = pdn; w2 = w1; w1 = ws;
    end
    e_filt  = (m_ph <= 1);
    e_zero  = (m_ph != 3);
    e_ready = (m_ph == 3);
    e_l = (m_ph == 3) ? l_in : '0;
    e_r = (m_ph == 3) ? r_in : '0;
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    string tag;
    if (mvalid && !finished) begin
      case (m_ph)
        0: tag = "R9";
        1: tag = "R5";
        2: tag = "R6";
        default: tag = "R7";
      endcase
      check({filt_rst_o, zero_force_o, ready_o} == {e_filt, e_zero, e_ready},
            tag, "flags{filt,zero,ready}", {filt_rst_o, zero_force_o, ready_o},
            {e_filt, e_zero, e_ready});
      check(left_o == e_l && right_o == e_r, tag, "samples{l,r}",
            {left_o, right_o}, {e_l, e_r});
    end
  end

  task automatic wait_ready(output bit got);
    got = 0;
    for (int i = 0; i < 30000; i++) begin
      @(negedge clk);
      if (ready_o) begin got = 1; break; end
    end
  endtask

  task automatic run_init(input bit m, input bit f, input int target, input int extra,
                          input string tag, input bit flip_mid);
    int br, bf, n;
    bit got;
    master = m; i2s = f;
    pdn = 1'b0;
    repeat (8) @(negedge clk);
    pdn = 1'b1;
    br = rise_cnt; bf = fall_cnt;
    repeat (3) @(negedge clk);
    check(filt_rst_o == !m, m ? "R4" : "R5", "filt_rst three edges after release",
          filt_rst_o, !m);
    if (flip_mid) begin
      repeat (500) @(negedge clk);
      master = ~m; i2s = ~f;
    end
    wait_ready(got);
    check(got, tag, "ready reached", got, 1);
    n = f ? (fall_cnt - bf) : (rise_cnt - br);
    check(n >= target + extra && n <= target + extra + 1, tag,
          "frame edges from release to ready", n, target + extra);
    master = m; i2s = f;
  endtask

  initial begin
    bit got;
    rst = 1'b1; pdn = 1'b1; master = 1'b1; i2s = 1'b0;
    repeat (5) @(negedge clk);
    check(filt_rst_o && zero_force_o && !ready_o && left_o == '0 && right_o == '0,
          "R1", "reset state", {filt_rst_o, zero_force_o, ready_o}, 3'b110);
    rst = 1'b0;
    @(negedge clk);
    check(filt_rst_o && zero_force_o && !ready_o, "R1", "first cycle after reset",
          {filt_rst_o, zero_force_o, ready_o}, 3'b110);

    // R2: no pulse on the pin yet, so no start
    repeat (60) @(negedge clk);
    check(filt_rst_o && !ready_o, "R2", "held off without power-down pulse",
          {filt_rst_o, ready_o}, 2'b10);

    // R4: master, left-justified
    run_init(1'b1, 1'b0, MF, 0, "R4", 1'b0);
    // R6: live data passes one edge later
    @(negedge clk);
    check(left_o == l_in && right_o == r_in, "R6", "passthrough",
          {left_o, right_o}, {l_in, r_in});
    // R7: ready holds
    repeat (300) @(negedge clk);
    check(ready_o, "R7", "ready holds", ready_o, 1);

    // R5: slave, both framings
    run_init(1'b0, 1'b0, SF, 1, "R5", 1'b0);
    run_init(1'b0, 1'b1, SF, 1, "R5", 1'b0);

    // R3: abort mid-count, then full new count
    master = 1'b1; i2s = 1'b0;
    pdn = 1'b0;
    repeat (8) @(negedge clk);
    pdn = 1'b1;
    repeat (1000) @(negedge clk);
    pdn = 1'b0;
    repeat (3) @(negedge clk);
    check(filt_rst_o && zero_force_o && !ready_o, "R3", "abort returns to power-down",
          {filt_rst_o, zero_force_o, ready_o}, 3'b110);
    check(filt_rst_o, "R9", "filter reset in power-down", filt_rst_o, 1);
    run_init(1'b1, 1'b0, MF, 0, "R3", 1'b0);

    // R8: slave left-justified, role and format flipped mid-count
    run_init(1'b0, 1'b0, SF, 1, "R8", 1'b1);

    repeat (10) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule